// File: doc/BRIEF.md
# Converter Sample Link Framer

This block turns a stream of 14-bit converter samples into octets for a serial transmit link. Each sample becomes a 16-bit word: the sample occupies the upper fourteen bits, optionally with its bit order reversed, and two zero bits fill the bottom. The word is cut into a high octet and a low octet. In single-lane mode both octets leave on lane 1, high first, and form one two-octet frame. In two-lane mode every clock carries one frame per lane: the high octet on lane 1 and the low octet on lane 2, with one frame counter shared by both lanes.

A frame counter groups frames into multiframes. The block flags the last octet of every frame and the last octet of every multiframe. When the last octet of a frame equals the last data octet of the previous frame on the same lane, the block sends an alignment control character in its place and raises that lane's control flag. The character is 0xFC inside a multiframe and 0x7C at the end of a multiframe. The frame size and the multiframe length each have a default and a separate override enable. The multiframe-length default depends on the frame size that is in effect.

The block produces one octet slot per lane per clock. Its outputs are registered and follow the slot by one clock. A link-start pulse returns the counters to the first octet of frame 0 and clears the alignment history.

Top module: `link_framer`

## Requirements
- R1: While `rstN` is low, every output is zero. The first slot after reset is octet 0 of frame 0, and the alignment history is empty.
- R2: The framing word is {sample, 2'b00}. The high octet is word bits 15:8 and the low octet is word bits 7:0. Each octet appears on the outputs one clock after its slot.
- R3: Single-lane mode. Lane 1 carries the high octet in the slot where the frame counter is at octet 0, and the low octet in the next slot. `sampleIn` is read only in the octet-0 slot. `lane2Oct` and `lane2K` stay 0.
- R4: Two-lane mode. In every slot, lane 1 carries the high octet and lane 2 carries the low octet. Each slot is a complete frame, so `frameEnd` is 1 for every slot.
- R5: `fCfg` has effect only when `fOvrEn` is 1. The frame size in effect is then `fCfg`: 0 selects two-lane mode and any nonzero value selects two octets per frame. When `fOvrEn` is 0, the frame size in effect is 1, which is single-lane mode.
- R6: With `kOvrEn` at 0, a multiframe has 9 frames in single-lane mode and 17 frames in two-lane mode. `mfEnd` is 1 together with `frameEnd` on the last octet of the last frame.
- R7: With `kOvrEn` at 1, a multiframe has `kCfg`+1 frames (for example, `kCfg`=22 gives 23 frames). With `kOvrEn` at 0, `kCfg` has no effect.
- R8: A lane's last frame octet that equals the previous frame's last data octet on that lane is replaced. The replacement is 0xFC with the lane's K flag at 1, or 0x7C with the K flag at 1 when `mfEnd` is 1. The comparison uses the data octet, not the character that was sent. The first octet of a single-lane frame is never replaced.
- R9: Reset and `linkStart` empty the alignment history, so the first frame after either one is never replaced.
- R10: A `linkStart` high in a slot lets that slot's output proceed as normal. The next slot is then octet 0 of frame 0.
- R11: With `flipEn` at 1, sample bit i is placed where bit 13-i would be before padding. The two zero bits stay at the bottom of the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one octet slot per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| linkStart | input | 1 | Restart framing at frame 0 and clear the alignment history |
| sampleIn | input | 14 | Converter sample |
| flipEn | input | 1 | Reverse the sample bit order before padding |
| fOvrEn | input | 1 | Use `fCfg` instead of the default frame size |
| fCfg | input | 8 | Octets per frame minus one (0 selects two-lane mode) |
| kOvrEn | input | 1 | Use `kCfg` instead of the default multiframe length |
| kCfg | input | 5 | Frames per multiframe minus one |
| lane1Oct | output | 8 | Lane 1 octet |
| lane1K | output | 1 | Lane 1 octet is a control character |
| lane2Oct | output | 8 | Lane 2 octet (zero in single-lane mode) |
| lane2K | output | 1 | Lane 2 octet is a control character |
| frameEnd | output | 1 | Current octet closes a frame |
| mfEnd | output | 1 | Current octet closes a multiframe |

## Verification
Alignment replacement and the end of a multiframe can fall on the same octet, and the replacement character must then switch from 0xFC to 0x7C. The bench provokes this by holding the sample constant for longer than a whole multiframe, in both lane modes and with default and overridden lengths. It then compares the code, the K flags, `frameEnd` and `mfEnd` in each slot against a model of the requirements. A restart in the middle of a multiframe is also placed next to repeated octets, to show that the cleared history takes precedence over the repeat.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int OCT_W = 8;
  localparam int LANES = 2;
  localparam logic [OCT_W-1:0] ALIGN_FRAME = 8'hFC;
  localparam logic [OCT_W-1:0] ALIGN_MULTI = 8'h7C;

  typedef struct packed {
    logic singleLane;
    logic firstOct;
    logic lastOct;
    logic mfLast;
    logic restart;
  } lf_strobe_t;
endpackage

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int FCFG_W   = 8,
  parameter int KCFG_W   = 5,
  parameter int KDEF_ONE = 16,
  parameter int KDEF_TWO = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkStart,
  input  logic              fOvrEn,
  input  logic [FCFG_W-1:0] fCfg,
  input  logic              kOvrEn,
  input  logic [KCFG_W-1:0] kCfg,
  output lf_strobe_t        strb
);
  localparam logic [KCFG_W-1:0] K_ONE = KCFG_W'(KDEF_ONE);
  localparam logic [KCFG_W-1:0] K_TWO = KCFG_W'(KDEF_TWO);

  logic              oneOctFrame;
  logic [KCFG_W-1:0] kEff;
  logic              octIdx;
  logic [KCFG_W-1:0] frameCnt;
  logic              lastOct;
  logic              mfLast;

  // Frame size in effect: only an enabled override of zero gives one octet per frame
  assign oneOctFrame = fOvrEn && (fCfg == '0);
  assign kEff        = kOvrEn ? kCfg : (oneOctFrame ? K_ONE : K_TWO);
  assign lastOct     = oneOctFrame || octIdx;
  assign mfLast      = lastOct && (frameCnt >= kEff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      octIdx   <= 1'b0;
      frameCnt <= '0;
    end else if (linkStart) begin
      octIdx   <= 1'b0;
      frameCnt <= '0;
    end else begin
      octIdx <= oneOctFrame ? 1'b0 : ~octIdx;
      if (lastOct) frameCnt <= mfLast ? '0 : frameCnt + 1'b1;
    end
  end

  always_comb begin
    strb.singleLane = !oneOctFrame;
    strb.firstOct   = !octIdx;
    strb.lastOct    = lastOct;
    strb.mfLast     = mfLast;
    strb.restart    = linkStart;
  end
endmodule

// File: rtl/lf_align_lane.sv
module lf_align_lane
  import lf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             active,
  input  logic [OCT_W-1:0] cand,
  input  logic             isLast,
  input  logic             mfLast,
  input  logic             clrHist,
  output logic [OCT_W-1:0] oct,
  output logic             isK
);
  logic [OCT_W-1:0] prevOct;
  logic             prevOk;
  logic             repeatHit;

  assign repeatHit = active && isLast && prevOk && (cand == prevOct);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oct <= '0;
      isK <= 1'b0;
    end else if (!active) begin
      oct <= '0;
      isK <= 1'b0;
    end else if (repeatHit) begin
      oct <= mfLast ? ALIGN_MULTI : ALIGN_FRAME;
      isK <= 1'b1;
    end else begin
      oct <= cand;
      isK <= 1'b0;
    end
  end

  // History keeps the data octet, never the substituted character
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOct <= '0;
      prevOk  <= 1'b0;
    end else if (clrHist) begin
      prevOk <= 1'b0;
    end else if (active && isLast) begin
      prevOct <= cand;
      prevOk  <= 1'b1;
    end
  end
endmodule

// File: rtl/lf_datapath.sv
module lf_datapath
  import lf_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SAMPLE_W-1:0]         sampleIn,
  input  logic                        flipEn,
  input  lf_strobe_t                  strb,
  output logic [LANES-1:0][OCT_W-1:0] laneOct,
  output logic [LANES-1:0]            laneK,
  output logic                        frameEnd,
  output logic                        mfEnd
);
  localparam int WORD_W = 2 * OCT_W;
  localparam int PAD_W  = WORD_W - SAMPLE_W;

  logic [SAMPLE_W-1:0]         revSample;
  logic [WORD_W-1:0]           word;
  logic [OCT_W-1:0]            hiOct;
  logic [OCT_W-1:0]            loOct;
  logic [OCT_W-1:0]            holdLo;
  logic [LANES-1:0][OCT_W-1:0] cand;
  logic [LANES-1:0]            laneActive;

  for (genvar i = 0; i < SAMPLE_W; i++) begin : g_rev
    assign revSample[i] = sampleIn[SAMPLE_W-1-i];
  end

  assign word  = {(flipEn ? revSample : sampleIn), {PAD_W{1'b0}}};
  assign hiOct = word[WORD_W-1:OCT_W];
  assign loOct = word[OCT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdLo <= '0;
    else if (strb.singleLane && strb.firstOct) holdLo <= loOct;
  end

  always_comb begin
    cand[0]       = (strb.singleLane && !strb.firstOct) ? holdLo : hiOct;
    cand[1]       = loOct;
    laneActive[0] = 1'b1;
    laneActive[1] = !strb.singleLane;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lf_align_lane u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .active (laneActive[l]),
      .cand   (cand[l]),
      .isLast (strb.lastOct),
      .mfLast (strb.mfLast),
      .clrHist(strb.restart),
      .oct    (laneOct[l]),
      .isK    (laneK[l])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameEnd <= 1'b0;
      mfEnd    <= 1'b0;
    end else begin
      frameEnd <= strb.lastOct;
      mfEnd    <= strb.mfLast;
    end
  end
endmodule

// File: rtl/link_framer.sv
module link_framer
  import lf_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int FCFG_W   = 8,
  parameter int KCFG_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                linkStart,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                flipEn,
  input  logic                fOvrEn,
  input  logic [FCFG_W-1:0]   fCfg,
  input  logic                kOvrEn,
  input  logic [KCFG_W-1:0]   kCfg,
  output logic [OCT_W-1:0]    lane1Oct,
  output logic                lane1K,
  output logic [OCT_W-1:0]    lane2Oct,
  output logic                lane2K,
  output logic                frameEnd,
  output logic                mfEnd
);
  lf_strobe_t                  strb;
  logic [LANES-1:0][OCT_W-1:0] laneOct;
  logic [LANES-1:0]            laneK;

  lf_ctrl #(.FCFG_W(FCFG_W), .KCFG_W(KCFG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .linkStart(linkStart),
    .fOvrEn   (fOvrEn),
    .fCfg     (fCfg),
    .kOvrEn   (kOvrEn),
    .kCfg     (kCfg),
    .strb     (strb)
  );

  lf_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sampleIn(sampleIn),
    .flipEn  (flipEn),
    .strb    (strb),
    .laneOct (laneOct),
    .laneK   (laneK),
    .frameEnd(frameEnd),
    .mfEnd   (mfEnd)
  );

  assign lane1Oct = laneOct[0];
  assign lane1K   = laneK[0];
  assign lane2Oct = laneOct[1];
  assign lane2K   = laneK[1];
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int FCFG_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              fOvrEn,
  input logic [FCFG_W-1:0] fCfg,
  input logic [7:0]        lane1Oct,
  input logic              lane1K,
  input logic [7:0]        lane2Oct,
  input logic              lane2K,
  input logic              frameEnd,
  input logic              mfEnd
);
  logic twoLaneCfg;
  assign twoLaneCfg = fOvrEn && (fCfg == '0);

  assert_mf_in_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    mfEnd |-> frameEnd);

  assert_lane1_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    lane1K |-> (lane1Oct == (mfEnd ? 8'h7C : 8'hFC)));

  assert_lane2_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    lane2K |-> (lane2Oct == (mfEnd ? 8'h7C : 8'hFC)));

  assert_k_at_frame_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lane1K || lane2K) |-> frameEnd);

  assert_lane2_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(twoLaneCfg) |-> (lane2Oct == 8'h00 && !lane2K));
endmodule

bind link_framer lf_checker #(.FCFG_W(FCFG_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .fOvrEn  (fOvrEn),
  .fCfg    (fCfg),
  .lane1Oct(lane1Oct),
  .lane1K  (lane1K),
  .lane2Oct(lane2Oct),
  .lane2K  (lane2K),
  .frameEnd(frameEnd),
  .mfEnd   (mfEnd)
);

// File: tb/link_framer_tb.sv
module link_framer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       linkStart = 1'b0;
  logic [13:0] sampleIn = '0;
  logic       flipEn = 1'b0;
  logic       fOvrEn = 1'b1;
  logic [7:0] fCfg = 8'd0;
  logic       kOvrEn = 1'b0;
  logic [4:0] kCfg = 5'd0;
  logic [7:0] lane1Oct, lane2Oct;
  logic       lane1K, lane2K, frameEnd, mfEnd;

  int nTests = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  link_framer u_dut (
    .clk(clk), .rstN(rstN), .linkStart(linkStart), .sampleIn(sampleIn),
    .flipEn(flipEn), .fOvrEn(fOvrEn), .fCfg(fCfg), .kOvrEn(kOvrEn), .kCfg(kCfg),
    .lane1Oct(lane1Oct), .lane1K(lane1K), .lane2Oct(lane2Oct), .lane2K(lane2K),
    .frameEnd(frameEnd), .mfEnd(mfEnd)
  );

  // Packing vectors in two-lane mode: {flip, sample, expected word}
  localparam int NVEC = 8;
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 14'h3FFF, 16'hFFFC},
    {1'b0, 14'h0001, 16'h0004},
    {1'b0, 14'h2000, 16'h8000},
    {1'b1, 14'h2000, 16'h0004},
    {1'b0, 14'h1234, 16'h48D0},
    {1'b1, 14'h1234, 16'h2C48},
    {1'b0, 14'h0155, 16'h0554},
    {1'b0, 14'h2AAA, 16'hAAA8}
  };

  // Requirement model state
  logic       mOct = 1'b0;
  int         mFrm = 0;
  logic [7:0] mPrev [2] = '{8'h00, 8'h00};
  logic       mOk [2] = '{1'b0, 1'b0};
  logic [7:0] mHold = 8'h00;

  function automatic logic [13:0] rev14(input logic [13:0] s);
    logic [13:0] r;
    for (int i = 0; i < 14; i++) r[i] = s[13-i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One slot: drive, model, clock, compare
  task automatic runSlot(input logic [13:0] s, input logic ls, input string tag);
    logic twoLane, last, mf;
    int kE;
    logic [15:0] w;
    logic [7:0] c1, c2, e1, e2;
    logic k1, k2;
    sampleIn = s;
    linkStart = ls;
    twoLane = fOvrEn && (fCfg == 8'd0);
    kE = kOvrEn ? int'(kCfg) : (twoLane ? 16 : 8);
    w = {(flipEn ? rev14(s) : s), 2'b00};
    last = twoLane || mOct;
    c1 = (!twoLane && mOct) ? mHold : w[15:8];
    c2 = w[7:0];
    mf = last && (mFrm >= kE);
    e1 = c1; k1 = 1'b0; e2 = 8'h00; k2 = 1'b0;
    if (last && mOk[0] && c1 == mPrev[0]) begin e1 = mf ? 8'h7C : 8'hFC; k1 = 1'b1; end
    if (twoLane) begin
      e2 = c2;
      if (mOk[1] && c2 == mPrev[1]) begin e2 = mf ? 8'h7C : 8'hFC; k2 = 1'b1; end
    end
    if (!twoLane && !mOct) mHold = c2;
    if (last) begin
      mPrev[0] = c1; mOk[0] = 1'b1;
      if (twoLane) begin mPrev[1] = c2; mOk[1] = 1'b1; end
      mFrm = mf ? 0 : mFrm + 1;
    end
    mOct = twoLane ? 1'b0 : ~mOct;
    if (ls) begin mOct = 1'b0; mFrm = 0; mOk[0] = 1'b0; mOk[1] = 1'b0; end
    @(posedge clk);
    #1;
    linkStart = 1'b0;
    check(tag, {lane1Oct, lane1K, lane2Oct, lane2K, frameEnd, mfEnd},
          {e1, k1, e2, k2, last, mf});
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", {lane1Oct, lane1K, lane2Oct, lane2K, frameEnd, mfEnd}, 20'h0);
    rstN = 1'b1;

    // R2 R4 R11: packing table in two-lane mode, starting at frame 0 after reset
    for (int v = 0; v < NVEC; v++) begin
      flipEn = VEC[v][30];
      runSlot(VEC[v][29:16], 1'b0, "R4 two-lane slot");
      nTests++;
      if ({lane1Oct, lane2Oct} !== VEC[v][15:0]) begin
        nFail++;
        $display("FAIL R2/R11 packing vec %0d: actual %h expected %h", v,
                 {lane1Oct, lane2Oct}, VEC[v][15:0]);
      end
    end
    flipEn = 1'b0;

    // R6 R8: two-lane default 17 frames, constant data gives 0xFC then 0x7C at the end
    runSlot(14'h0ABC, 1'b1, "R10 restart slot");
    for (int i = 0; i < 36; i++) runSlot(14'h0ABC, 1'b0, "R6/R8 two-lane multiframe");

    // R5 R3 R6 R7: fCfg ignored without override, kCfg ignored without override
    fOvrEn = 1'b0; fCfg = 8'd0; kCfg = 5'd3;
    runSlot(14'h1111, 1'b1, "R10 restart slot");
    for (int i = 0; i < 40; i++) runSlot(14'h1111, 1'b0, "R5/R3/R6/R8 single-lane default");

    // R5: an enabled nonzero frame size stays single-lane
    fOvrEn = 1'b1; fCfg = 8'd5;
    for (int i = 0; i < 6; i++) runSlot(14'(i * 37), 1'b0, "R5 nonzero override");

    // R3: sample read only in the octet-0 slot, changed every cycle
    fOvrEn = 1'b0;
    runSlot(14'h0000, 1'b1, "R10 restart slot");
    for (int i = 0; i < 12; i++) runSlot(14'(i * 613 + 5), 1'b0, "R3 sample hold");

    // R7: override of 3 frames in two-lane mode, constant data
    fOvrEn = 1'b1; fCfg = 8'd0; kOvrEn = 1'b1; kCfg = 5'd2;
    runSlot(14'h0777, 1'b1, "R10 restart slot");
    for (int i = 0; i < 9; i++) runSlot(14'h0777, 1'b0, "R7 three-frame multiframe");

    // R7: override of 23 frames in single-lane mode
    fOvrEn = 1'b0; kCfg = 5'd22;
    runSlot(14'h0321, 1'b1, "R10 restart slot");
    for (int i = 0; i < 50; i++) runSlot(14'h0321, 1'b0, "R7 23-frame multiframe");

    // R9 R10: restart in mid-multiframe next to repeated data
    fOvrEn = 1'b1; fCfg = 8'd0; kOvrEn = 1'b0;
    for (int i = 0; i < 5; i++) runSlot(14'h2222, 1'b0, "R8 repeat before restart");
    runSlot(14'h2222, 1'b1, "R10 restart slot");
    runSlot(14'h2222, 1'b0, "R9 first frame after restart not replaced");
    for (int i = 0; i < 20; i++) runSlot(14'h2222, 1'b0, "R10 multiframe restarted");

    // R11: reversal in single-lane mode
    fOvrEn = 1'b0; flipEn = 1'b1;
    runSlot(14'h0001, 1'b1, "R10 restart slot");
    for (int i = 0; i < 10; i++) runSlot(14'(14'h0001 << i), 1'b0, "R11 flip single-lane");
    flipEn = 1'b0;

    // R1: reset in mid-stream clears outputs and history
    rstN = 1'b0;
    #1;
    check("R1 reset mid-stream", {lane1Oct, lane1K, lane2Oct, lane2K, frameEnd, mfEnd}, 20'h0);
    mOct = 1'b0; mFrm = 0; mOk[0] = 1'b0; mOk[1] = 1'b0; mHold = 8'h00;
    @(posedge clk);
    #1;
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) runSlot(14'h0321, 1'b0, "R9 after reset");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule